// File: doc/BRIEF.md
# Full-Map Directory Coherence Controller

This block sits at the memory side of a small shared-memory system and keeps, for every memory block, a full vector of presence bits (one per processor) and a single dirty bit. Processors send it read requests (share a copy) and write requests (take ownership), each tagged with the requester's number. The controller then decides from the directory entry whether memory can answer directly, or whether caches must first be told to give up or downgrade their copies.

When other caches must act, the controller sends one multicast message, carrying a mask of target processors, and then collects one acknowledgement from each target. A recall asks a dirty owner to return its data and keep a shared copy. An invalidate asks every target to drop its copy, and a dirty owner also returns its data. Returned dirty data is written to the backing memory and forwarded to the requester. Otherwise, the data comes from a one-cycle synchronous memory read. Only one transaction is in progress at a time, and the request port is held not-ready until it completes. The network is taken to be reliable and in order, so no retries or reordering are handled.

Top module: `coh_dir`

## Requirements
- R1: After reset every directory entry is clear (no presence bits, dirty bit 0): `req_ready` is 1, `msg_valid`, `rsp_valid` and `mem_wr` are 0, and the first request to any block is answered from memory with no message sent.
- R2: A read of a clean block sends no message. It reads memory and asserts `rsp_valid`, with `rsp_id` equal to the requester and `rsp_data` equal to the memory word, exactly 3 cycles after the cycle in which the request was accepted. It also adds the requester to the block's presence bits.
- R3: A read of a dirty block sends one message with `msg_kind` = 0 (recall) and `msg_mask` holding only the owner's bit. After the owner's acknowledgement, the acknowledged data is written to memory at the block address and returned to the requester. The block becomes clean, and both the owner and the requester remain sharers, so a later write by a third processor must invalidate exactly those two.
- R4: A write to a clean block with other sharers sends one message with `msg_kind` = 1 (invalidate), whose mask is every presence bit except the requester's. The response carries the memory word. Afterwards only the requester's presence bit is set and the block is dirty.
- R5: A write to a dirty block sends an invalidate (`msg_kind` = 1) to the owner, even when the owner is the requester. The owner's acknowledged data is written to memory and forwarded to the requester, who becomes the sole, dirty owner.
- R6: `req_ready` is 0 from the cycle after a request is accepted up to and including the cycle of `rsp_valid`, and returns to 1 in the next cycle.
- R7: The response waits until an acknowledgement has been received from every processor in the message mask. An acknowledgement whose `ack_id` is not in the mask is ignored and does not complete the transaction.
- R8: A write to a clean block that has no sharer other than the requester sends no message and is answered from memory 3 cycles after acceptance.
- R9: Each transaction that needs caches to act produces exactly one message, with `msg_valid` high for a single cycle, a nonzero mask and `msg_addr` equal to the request address. No other transaction produces any message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_write | input | 1 | 1 = write (take ownership), 0 = read (share) |
| req_id | input | IDW | Requesting processor number |
| req_addr | input | AW | Memory block index |
| msg_valid | output | 1 | Coherence message valid, one cycle |
| msg_kind | output | 1 | 0 = recall to shared, 1 = invalidate |
| msg_mask | output | NPROC | Target processors of the message |
| msg_addr | output | AW | Block the message refers to |
| ack_valid | input | 1 | Acknowledgement from a cache |
| ack_id | input | IDW | Processor sending the acknowledgement |
| ack_data | input | DW | Block data returned by a dirty owner |
| mem_rd | output | 1 | Backing memory read strobe (data next cycle) |
| mem_wr | output | 1 | Backing memory write strobe |
| mem_addr | output | AW | Backing memory block index |
| mem_wdata | output | DW | Write-back data |
| mem_rdata | input | DW | Read data, valid the cycle after `mem_rd` |
| rsp_valid | output | 1 | Data response valid, one cycle |
| rsp_id | output | IDW | Processor the response goes to |
| rsp_data | output | DW | Block data for the requester |

## Verification
A corrupted presence vector does not show at once. It appears at the next write to that block, as a missing or extra bit in `msg_mask`, one cycle after that write is accepted. A wrong dirty bit shows at the next access to the block in one of two ways: a read is served from memory without the required recall, or a recall is sent to a cache that owns nothing. In both cases the response then carries stale data. Lost or miscounted acknowledgements show as a response that comes too early, before every target has answered, or as a controller that never becomes ready again. The bench therefore chains requests to the same block, so that every directory update is read back through the mask and data of a later transaction.

// File: rtl/coh_pkg.sv
package coh_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND,
      ST_WAIT,
      ST_WB,
      ST_RD,
      ST_CAP,
      ST_RSP
   } ctl_st_t;

   localparam logic MSG_RECALL = 1'b0;
   localparam logic MSG_INV    = 1'b1;
endpackage

// File: rtl/coh_dir_store.sv
module coh_dir_store #(
   parameter int NPROC = 4,
   parameter int AW    = 3,
   localparam int NBLK = 1 << AW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    rd_addr,
   output logic [NPROC-1:0] rd_pres,
   output logic             rd_dirty,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [NPROC-1:0] wr_pres,
   input  logic             wr_dirty
);
   logic [NPROC-1:0] pres_q [NBLK];
   logic             dirty_q [NBLK];

   for (genvar g = 0; g < NBLK; g++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pres_q[g]  <= '0;
            dirty_q[g] <= 1'b0;
         end else if (wr_en && wr_addr == AW'(g)) begin
            pres_q[g]  <= wr_pres;
            dirty_q[g] <= wr_dirty;
         end
      end
   end

   assign rd_pres  = pres_q[rd_addr];
   assign rd_dirty = dirty_q[rd_addr];
endmodule

// File: rtl/coh_req_decode.sv
module coh_req_decode #(
   parameter int NPROC = 4
) (
   input  logic             is_wr,
   input  logic [NPROC-1:0] req_oh,
   input  logic [NPROC-1:0] pres,
   input  logic             dirty,
   output logic             need_msg,
   output logic [NPROC-1:0] tgt_mask,
   output logic             kind,
   output logic             fetch
);
   import coh_pkg::*;

   logic [NPROC-1:0] others;
   assign others = pres & ~req_oh;

   always_comb begin
      need_msg = 1'b0;
      tgt_mask = '0;
      kind     = MSG_RECALL;
      fetch    = 1'b0;
      if (dirty) begin
         need_msg = 1'b1;
         tgt_mask = pres;
         kind     = is_wr ? MSG_INV : MSG_RECALL;
         fetch    = 1'b1;
      end else if (is_wr && others != '0) begin
         need_msg = 1'b1;
         tgt_mask = others;
         kind     = MSG_INV;
      end
   end
endmodule

// File: rtl/coh_ack_track.sv
module coh_ack_track #(
   parameter int NPROC = 4,
   localparam int IDW  = $clog2(NPROC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NPROC-1:0] load_mask,
   input  logic             ack_valid,
   input  logic [IDW-1:0]   ack_id,
   output logic             hit,
   output logic             all_done
);
   logic [NPROC-1:0] pend_q;
   logic [NPROC-1:0] ack_oh;

   assign ack_oh   = {{(NPROC-1){1'b0}}, 1'b1} << ack_id;
   assign hit      = ack_valid && ((pend_q & ack_oh) != '0);
   assign all_done = (pend_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= '0;
      else if (load)
         pend_q <= load_mask;
      else if (hit)
         pend_q <= pend_q & ~ack_oh;
   end
endmodule

// File: rtl/coh_dir.sv
module coh_dir #(
   parameter int NPROC = 4,
   parameter int AW    = 3,
   parameter int DW    = 16,
   localparam int IDW  = $clog2(NPROC)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [IDW-1:0]   req_id,
   input  logic [AW-1:0]    req_addr,
   output logic             msg_valid,
   output logic             msg_kind,
   output logic [NPROC-1:0] msg_mask,
   output logic [AW-1:0]    msg_addr,
   input  logic             ack_valid,
   input  logic [IDW-1:0]   ack_id,
   input  logic [DW-1:0]    ack_data,
   output logic             mem_rd,
   output logic             mem_wr,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic [DW-1:0]    mem_rdata,
   output logic             rsp_valid,
   output logic [IDW-1:0]   rsp_id,
   output logic [DW-1:0]    rsp_data
);
   import coh_pkg::*;

   if (NPROC < 2) begin : g_bad_nproc
      $error("coh_dir: NPROC must be at least 2");
   end
   if (NPROC != (1 << IDW)) begin : g_bad_pow2
      $error("coh_dir: NPROC must be a power of two");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("coh_dir: AW and DW must be positive");
   end

   ctl_st_t          st_q;
   logic [IDW-1:0]   id_q;
   logic [AW-1:0]    addr_q;
   logic             wr_q;
   logic             kind_q;
   logic             fetch_q;
   logic [NPROC-1:0] mask_q;
   logic [DW-1:0]    data_q;

   logic             acc;
   logic [NPROC-1:0] req_oh;
   logic [NPROC-1:0] id_oh_q;
   logic [AW-1:0]    dir_raddr;
   logic [NPROC-1:0] dir_pres;
   logic             dir_dirty;
   logic             dir_we;
   logic [NPROC-1:0] dir_wpres;
   logic             dec_msg;
   logic [NPROC-1:0] dec_mask;
   logic             dec_kind;
   logic             dec_fetch;
   logic             trk_hit;
   logic             trk_done;

   assign req_ready = (st_q == ST_IDLE);
   assign acc       = req_valid && req_ready;
   assign req_oh    = {{(NPROC-1){1'b0}}, 1'b1} << req_id;
   assign id_oh_q   = {{(NPROC-1){1'b0}}, 1'b1} << id_q;
   assign dir_raddr = (st_q == ST_IDLE) ? req_addr : addr_q;

   coh_dir_store #(.NPROC(NPROC), .AW(AW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_addr  (dir_raddr),
      .rd_pres  (dir_pres),
      .rd_dirty (dir_dirty),
      .wr_en    (dir_we),
      .wr_addr  (addr_q),
      .wr_pres  (dir_wpres),
      .wr_dirty (wr_q)
   );

   coh_req_decode #(.NPROC(NPROC)) u_dec (
      .is_wr    (req_write),
      .req_oh   (req_oh),
      .pres     (dir_pres),
      .dirty    (dir_dirty),
      .need_msg (dec_msg),
      .tgt_mask (dec_mask),
      .kind     (dec_kind),
      .fetch    (dec_fetch)
   );

   coh_ack_track #(.NPROC(NPROC)) u_trk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (acc && dec_msg),
      .load_mask (dec_mask),
      .ack_valid (ack_valid),
      .ack_id    (ack_id),
      .hit       (trk_hit),
      .all_done  (trk_done)
   );

   assign dir_we    = (st_q == ST_RSP);
   assign dir_wpres = wr_q ? id_oh_q : (dir_pres | id_oh_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         id_q    <= '0;
         addr_q  <= '0;
         wr_q    <= 1'b0;
         kind_q  <= MSG_RECALL;
         fetch_q <= 1'b0;
         mask_q  <= '0;
         data_q  <= '0;
      end else begin
         if (trk_hit && fetch_q)
            data_q <= ack_data;
         unique case (st_q)
            ST_IDLE: begin
               if (acc) begin
                  id_q    <= req_id;
                  addr_q  <= req_addr;
                  wr_q    <= req_write;
                  kind_q  <= dec_kind;
                  fetch_q <= dec_fetch;
                  mask_q  <= dec_mask;
                  st_q    <= dec_msg ? ST_SEND : ST_RD;
               end
            end
            ST_SEND: st_q <= ST_WAIT;
            ST_WAIT: begin
               if (trk_done)
                  st_q <= fetch_q ? ST_WB : ST_RD;
            end
            ST_WB:  st_q <= ST_RSP;
            ST_RD:  st_q <= ST_CAP;
            ST_CAP: begin
               data_q <= mem_rdata;
               st_q   <= ST_RSP;
            end
            ST_RSP:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign msg_valid = (st_q == ST_SEND);
   assign msg_kind  = kind_q;
   assign msg_mask  = mask_q;
   assign msg_addr  = addr_q;

   assign mem_rd    = (st_q == ST_RD);
   assign mem_wr    = (st_q == ST_WB);
   assign mem_addr  = addr_q;
   assign mem_wdata = data_q;

   assign rsp_valid = (st_q == ST_RSP);
   assign rsp_id    = id_q;
   assign rsp_data  = data_q;
endmodule

// File: rtl/coh_dir_chk.sv
module coh_dir_chk #(
   parameter int NPROC = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic             msg_valid,
   input logic [NPROC-1:0] msg_mask,
   input logic             rsp_valid,
   input logic             mem_rd,
   input logic             mem_wr
);
   a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   a_r6_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> req_ready);

   a_r6_rsp_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);

   a_r9_msg_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> !msg_valid);

   a_r9_msg_has_target: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (msg_mask != '0));

   a_r9_msg_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> !req_ready);

   a_r7_no_rsp_with_msg: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |=> !rsp_valid);

   a_r2_mem_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   a_r2_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
endmodule

bind coh_dir coh_dir_chk #(.NPROC(NPROC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .msg_valid (msg_valid),
   .msg_mask  (msg_mask),
   .rsp_valid (rsp_valid),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr)
);

// File: tb/coh_dir_test.sv
module coh_dir_test;
   localparam int NPROC = 4;
   localparam int AW    = 3;
   localparam int DW    = 16;
   localparam int IDW   = 2;
   localparam int NBLK  = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic             req_write = 1'b0;
   logic [IDW-1:0]   req_id = '0;
   logic [AW-1:0]    req_addr = '0;
   logic             msg_valid;
   logic             msg_kind;
   logic [NPROC-1:0] msg_mask;
   logic [AW-1:0]    msg_addr;
   logic             ack_valid = 1'b0;
   logic [IDW-1:0]   ack_id = '0;
   logic [DW-1:0]    ack_data = '0;
   logic             mem_rd;
   logic             mem_wr;
   logic [AW-1:0]    mem_addr;
   logic [DW-1:0]    mem_wdata;
   logic [DW-1:0]    mem_rdata;
   logic             rsp_valid;
   logic [IDW-1:0]   rsp_id;
   logic [DW-1:0]    rsp_data;

   always #5 clk = ~clk;

   coh_dir #(.NPROC(NPROC), .AW(AW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_id(req_id), .req_addr(req_addr),
      .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_mask(msg_mask), .msg_addr(msg_addr),
      .ack_valid(ack_valid), .ack_id(ack_id), .ack_data(ack_data),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data)
   );

   // backing memory model, synchronous read
   logic [DW-1:0] bmem [NBLK];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NBLK; i++) bmem[i] <= DW'(16'h1000 + i);
         mem_rdata <= '0;
      end else begin
         if (mem_wr) bmem[mem_addr] <= mem_wdata;
         if (mem_rd) mem_rdata <= bmem[mem_addr];
      end
   end

   // reference model state
   int ref_pres [NBLK];
   bit ref_dirty [NBLK];
   int ref_mem [NBLK];

   int errors = 0;
   int total  = 0;
   bit finished = 0;

   int msg_cnt, wb_cnt, rsp_cnt;
   int seen_mask, seen_kind, seen_maddr;
   int wb_addr, wb_data, got_id, got_data;
   bit busy = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      if (busy) check(!req_ready, "R6 ready while busy", int'(req_ready), 0);
      if (msg_valid) begin
         msg_cnt++;
         seen_mask  = int'(msg_mask);
         seen_kind  = int'(msg_kind);
         seen_maddr = int'(msg_addr);
      end
      if (mem_wr) begin
         wb_cnt++;
         wb_addr = int'(mem_addr);
         wb_data = int'(mem_wdata);
      end
      if (rsp_valid) begin
         rsp_cnt++;
         got_id   = int'(rsp_id);
         got_data = int'(rsp_data);
         busy = 0;
      end
   endtask

   task automatic txn(input bit wr, input int id, input int addr, input bit stray, input int tno);
      int p, oh, emask, ekind, edata, n, owner, sid;
      bit emsg, efetch;
      p = ref_pres[addr];
      oh = 1 << id;
      emsg = 0; efetch = 0; emask = 0; ekind = 0; owner = 0;
      edata = ref_mem[addr];
      if (ref_dirty[addr]) begin
         emsg = 1; efetch = 1; emask = p; ekind = wr ? 1 : 0;
         for (int b = 0; b < NPROC; b++) if (p[b]) owner = b;
         edata = 16'hC000 + tno * 16 + owner;
      end else if (wr && ((p & ~oh) != 0)) begin
         emsg = 1; emask = p & ~oh; ekind = 1;
      end

      msg_cnt = 0; wb_cnt = 0; rsp_cnt = 0;
      check(req_ready, "R6 ready before request", int'(req_ready), 1);
      req_valid = 1'b1; req_write = wr; req_id = IDW'(id); req_addr = AW'(addr);
      n = 0;
      tick(); n++;
      busy = 1;
      req_valid = 1'b0;

      if (emsg) begin
         while (msg_cnt == 0 && n < 20) begin tick(); n++; end
         if (stray) begin
            sid = -1;
            for (int b = NPROC - 1; b >= 0; b--) if (!emask[b]) sid = b;
            if (sid >= 0) begin
               ack_valid = 1'b1; ack_id = IDW'(sid); ack_data = 16'hDEAD;
               tick(); n++;
               ack_valid = 1'b0;
               for (int k = 0; k < 3; k++) begin tick(); n++; end
               check(rsp_cnt == 0, "R7 stray ack completed transaction", rsp_cnt, 0);
            end
         end
         for (int b = 0; b < NPROC; b++) begin
            if (emask[b]) begin
               check(rsp_cnt == 0, "R7 response before all acks", rsp_cnt, 0);
               ack_valid = 1'b1; ack_id = IDW'(b); ack_data = DW'(16'hC000 + tno * 16 + b);
               tick(); n++;
               ack_valid = 1'b0;
            end
         end
      end
      while (rsp_cnt == 0 && n < 40) begin tick(); n++; end

      check(rsp_cnt == 1, "R2 one response", rsp_cnt, 1);
      check(got_id == id, "R2 response id", got_id, id);
      check(got_data == edata, emsg ? (efetch ? "R3/R5 forwarded owner data" : "R4 memory data")
                                    : "R2/R8 memory data", got_data, edata);
      check(msg_cnt == (emsg ? 1 : 0), "R9 message count", msg_cnt, emsg ? 1 : 0);
      if (emsg) begin
         check(seen_mask == emask, ekind ? "R4/R5 invalidate mask" : "R3 recall mask", seen_mask, emask);
         check(seen_kind == ekind, "R3/R4/R5 message kind", seen_kind, ekind);
         check(seen_maddr == addr, "R9 message address", seen_maddr, addr);
      end else begin
         check(n == 3, wr ? "R8 latency" : "R2 latency", n, 3);
      end
      check(wb_cnt == (efetch ? 1 : 0), "R3/R5 write-back count", wb_cnt, efetch ? 1 : 0);
      if (efetch) begin
         check(wb_addr == addr, "R3/R5 write-back address", wb_addr, addr);
         check(wb_data == edata, "R3/R5 write-back data", wb_data, edata);
      end
      tick();
      check(req_ready, "R6 ready after response", int'(req_ready), 1);

      if (efetch) ref_mem[addr] = edata;
      ref_pres[addr]  = wr ? oh : (p | oh);
      ref_dirty[addr] = wr;
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         errors++; total++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, total);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NBLK; i++) begin
         ref_pres[i] = 0; ref_dirty[i] = 0; ref_mem[i] = 16'h1000 + i;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state at the ports
      check(req_ready,  "R1 ready after reset", int'(req_ready), 1);
      check(!msg_valid, "R1 no message after reset", int'(msg_valid), 0);
      check(!rsp_valid, "R1 no response after reset", int'(rsp_valid), 0);
      check(!mem_wr,    "R1 no write after reset", int'(mem_wr), 0);

      txn(0, 0, 2, 0, 1);  // R1 R2 clean read
      txn(0, 1, 2, 0, 2);  // R2 second sharer
      txn(1, 2, 2, 1, 3);  // R4 R7 invalidate sharers 0,1 with stray ack
      txn(0, 3, 2, 0, 4);  // R3 recall dirty owner 2
      txn(0, 0, 2, 0, 5);  // R3 block now clean, memory holds recalled data
      txn(1, 1, 5, 0, 6);  // R8 write without sharers
      txn(1, 3, 5, 0, 7);  // R5 dirty write, owner 1
      txn(1, 3, 5, 0, 8);  // R5 dirty write by the owner itself
      txn(1, 0, 2, 1, 9);  // R3 R4 R7 invalidate sharers 2,3 left by the recall
      txn(0, 1, 7, 0, 10); // R2 top block
      txn(0, 2, 5, 0, 11); // R3 recall owner 3 on block 5

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
   end
endmodule